// File: doc/BRIEF.md
# I2C Target With Register Interface

This block is an I2C bus target that answers a software-programmed 7-bit address. A local processor reaches it through a small register bus. Events on the bus are reported in a status register: address match, byte received, byte transmitted, transmit data empty, STOP seen, transmit direction and general call. A matching enable register turns those events into a single interrupt line. One data register carries bytes in both directions. Writes load the next byte to transmit, and reads return the last byte received.

The block joins the bus through open-drain controls. `sda_oe` and `scl_oe` pull their lines low when high, and `sda_in` and `scl_in` sense the wired lines. To give software time to act, the target stretches the clock in three places: after its address is acknowledged, after each received byte and before each further transmit byte. It releases SCL once the matching status bit is cleared. A control bit lets software refuse a received byte by answering it with a NACK.

Register selects: 0 control, 1 status, 2 interrupt enable, 3 own address, 4 data. Control bits: bit0 refuse (NACK) received byte, bit1 general-call match enable, bit2 target enable, bit3 buffer-mode select (stored and read back only). Status and interrupt-enable bits: bit0 address matched, bit1 byte received, bit2 byte transmitted, bit3 transmit data empty, bit4 STOP seen, bit5 transmit direction, bit6 general call.

Top module: `i2c_target_core`

## Requirements
- R1: After reset every register reads 0, `irq` is 0 and neither SDA nor SCL is pulled low.
- R2: When enabled, the byte after a START is compared on its upper 7 bits with the own-address register bits 6:0. On a match the target pulls SDA low during the 9th clock and sets status bit0. On a mismatch it leaves SDA released, sets no status bit and ignores the bus until the next START or STOP.
- R3: A write to the status register clears each status bit whose written bit is 0 and leaves the bits written as 1 unchanged. An event that arrives in the same cycle sets its bit regardless of the write.
- R4: `irq` is high exactly when some status bit and the same bit of the interrupt-enable register are both 1.
- R5: On a match with R/W bit 1, status bit5 is set. When the hold is released, the target sends the data register contents MSB first, changing SDA only while SCL is low. Status bit3 is set at the moment each byte is taken from the data register.
- R6: On a match with R/W bit 0, status bit5 is cleared. Each byte then received MSB first is readable from the data register and sets status bit1.
- R7: SCL is held low in three cases. It is held after the address acknowledge while status bit0 is set. It is held after the 8th bit of a received byte while status bit1 is set. It is held after an acknowledged transmit byte while status bit3 is set.
- R8: The acknowledge of a received byte follows control bit0 as it stands when the hold of R7 ends. With 0 the target pulls SDA low (ACK). With 1 it leaves SDA released (NACK) and then waits for START or STOP.
- R9: During transmit, an ACK (SDA low on the 9th clock) sets status bit2 and moves on to the next byte. A NACK sets nothing, and the target keeps SDA released until START or STOP.
- R10: A STOP (SDA rising while SCL is high) seen after the target was addressed sets status bit4. The target returns to idle with SDA and SCL released.
- R11: With control bit1 set, the address byte 0x00 (R/W 0) is acknowledged and sets status bits 0 and 6. With control bit1 clear, that byte is not acknowledged.
- R12: With control bit2 clear, the target never pulls either line low and sets no status bit, even for its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | SEL_W | Register select |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| irq | output | 1 | Interrupt request |
| scl_in | input | 1 | Sensed SCL line |
| sda_in | input | 1 | Sensed SDA line |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The properties assume that SCL and SDA reach the block only through its synchronizer. They also assume a bus master that changes SDA only while SCL is low, except when it signals START or STOP. Both lines must stay stable for several block clocks between changes, so every edge is seen exactly once. The bench master spaces each edge by ten block clocks. It waits for SCL to read high before timing a clock pulse, so it obeys the stretch. All status servicing happens while the target is holding SCL or while the bus is idle, so software writes never race a bus event.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

   localparam int ST_AM  = 0;
   localparam int ST_RXD = 1;
   localparam int ST_TXD = 2;
   localparam int ST_TXE = 3;
   localparam int ST_STP = 4;
   localparam int ST_TXM = 5;
   localparam int ST_GC  = 6;
   localparam int ST_W   = 7;

   localparam int CT_NACK = 0;
   localparam int CT_GCEN = 1;
   localparam int CT_EN   = 2;
   localparam int CT_W    = 4;

   localparam int RA_CTRL = 0;
   localparam int RA_STAT = 1;
   localparam int RA_IEN  = 2;
   localparam int RA_OWN  = 3;
   localparam int RA_DATA = 4;

   localparam int DW = 8;
   localparam int AW = 7;

   typedef enum logic [3:0] {
      PH_IDLE, PH_ADDR, PH_ADDR_ACK, PH_HOLD, PH_RX_BITS,
      PH_RX_WAIT, PH_RX_ACK, PH_TX_BITS, PH_TX_ACK, PH_DONE
   } phase_e;

   typedef struct packed {
      logic am;
      logic rxd;
      logic txd;
      logic txe;
      logic stp;
      logic gc;
      logic tm_set;
      logic tm_clr;
   } evt_t;

endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic [1:0] raw, sync_q, prev_q;

   assign raw = {sda_in, scl_in};

   for (genvar g = 0; g < 2; g++) begin : g_line
      logic [STAGES-1:0] chain;
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= raw[g];
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw[g]};
         end
      end
      assign sync_q[g] = chain[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '1;
      else        prev_q <= sync_q;
   end

   assign sda_s     = sync_q[1];
   assign scl_rise  = sync_q[0] & ~prev_q[0];
   assign scl_fall  = ~sync_q[0] & prev_q[0];
   assign start_det = sync_q[0] & prev_q[0] & prev_q[1] & ~sync_q[1];
   assign stop_det  = sync_q[0] & prev_q[0] & ~prev_q[1] & sync_q[1];

   p_no_dual_edge_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !stop_det);

endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
   import i2ct_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sda_s,
   input  logic          scl_rise,
   input  logic          scl_fall,
   input  logic          start_det,
   input  logic          stop_det,
   input  logic          en,
   input  logic          gc_en,
   input  logic          force_nack,
   input  logic [AW-1:0] own_addr,
   input  logic [DW-1:0] tx_byte,
   input  logic          am_pend,
   input  logic          rxd_pend,
   input  logic          txe_pend,
   output logic          sda_low,
   output logic          scl_low,
   output logic [DW-1:0] rx_byte,
   output evt_t          ev
);

   localparam logic [3:0] LAST_BIT = 4'(DW - 1);
   localparam logic [3:0] FULL_CNT = 4'(DW);

   phase_e        phase;
   logic [3:0]    cnt;
   logic [DW-1:0] shreg;
   logic          rd_req, first, sel, mack;
   logic          own_hit, gc_hit, hold_busy;

   assign own_hit = (shreg[DW-1:1] == own_addr);
   assign gc_hit  = gc_en && (shreg == '0);

   always_comb begin
      if (first)       hold_busy = am_pend;
      else if (rd_req) hold_busy = txe_pend;
      else             hold_busy = 1'b0;
   end

   assign scl_low = en && ((phase == PH_RX_WAIT) || (phase == PH_HOLD && hold_busy));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         cnt     <= '0;
         shreg   <= '0;
         rd_req  <= 1'b0;
         first   <= 1'b0;
         sel     <= 1'b0;
         mack    <= 1'b0;
         sda_low <= 1'b0;
         rx_byte <= '0;
         ev      <= '0;
      end else begin
         ev <= '0;
         if (!en) begin
            phase   <= PH_IDLE;
            sda_low <= 1'b0;
            sel     <= 1'b0;
         end else if (stop_det) begin
            ev.stp  <= sel;
            sel     <= 1'b0;
            phase   <= PH_IDLE;
            sda_low <= 1'b0;
         end else if (start_det) begin
            phase   <= PH_ADDR;
            cnt     <= '0;
            sda_low <= 1'b0;
         end else begin
            case (phase)
               PH_ADDR: begin
                  if (scl_rise) begin
                     shreg <= {shreg[DW-2:0], sda_s};
                     cnt   <= cnt + 4'd1;
                  end else if (scl_fall && cnt == FULL_CNT) begin
                     if (own_hit || gc_hit) begin
                        phase     <= PH_ADDR_ACK;
                        sda_low   <= 1'b1;
                        ev.am     <= 1'b1;
                        ev.gc     <= gc_hit;
                        ev.tm_set <= shreg[0];
                        ev.tm_clr <= ~shreg[0];
                        rd_req    <= shreg[0];
                        sel       <= 1'b1;
                     end else begin
                        phase <= PH_DONE;
                     end
                  end
               end
               PH_ADDR_ACK: begin
                  if (scl_fall) begin
                     sda_low <= 1'b0;
                     first   <= 1'b1;
                     phase   <= PH_HOLD;
                  end
               end
               PH_HOLD: begin
                  if (!hold_busy) begin
                     cnt   <= '0;
                     first <= 1'b0;
                     if (rd_req) begin
                        shreg   <= tx_byte;
                        sda_low <= ~tx_byte[DW-1];
                        ev.txe  <= 1'b1;
                        phase   <= PH_TX_BITS;
                     end else begin
                        phase <= PH_RX_BITS;
                     end
                  end
               end
               PH_TX_BITS: begin
                  if (scl_fall) begin
                     cnt <= cnt + 4'd1;
                     if (cnt == LAST_BIT) begin
                        sda_low <= 1'b0;
                        phase   <= PH_TX_ACK;
                     end else begin
                        shreg   <= {shreg[DW-2:0], 1'b0};
                        sda_low <= ~shreg[DW-2];
                     end
                  end
               end
               PH_TX_ACK: begin
                  if (scl_rise) begin
                     mack   <= ~sda_s;
                     ev.txd <= ~sda_s;
                  end else if (scl_fall) begin
                     phase <= mack ? PH_HOLD : PH_DONE;
                  end
               end
               PH_RX_BITS: begin
                  if (scl_rise) begin
                     shreg <= {shreg[DW-2:0], sda_s};
                     cnt   <= cnt + 4'd1;
                  end else if (scl_fall && cnt == FULL_CNT) begin
                     rx_byte <= shreg;
                     ev.rxd  <= 1'b1;
                     phase   <= PH_RX_WAIT;
                  end
               end
               PH_RX_WAIT: begin
                  if (!rxd_pend && !ev.rxd) begin
                     sda_low <= ~force_nack;
                     mack    <= ~force_nack;
                     phase   <= PH_RX_ACK;
                  end
               end
               PH_RX_ACK: begin
                  if (scl_fall) begin
                     sda_low <= 1'b0;
                     cnt     <= '0;
                     phase   <= mack ? PH_RX_BITS : PH_DONE;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   p_stop_idle_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (en && stop_det) |=> (phase == PH_IDLE && !sda_low));

   p_rx_hold_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (en && phase == PH_RX_WAIT && rxd_pend && !stop_det && !start_det)
      |=> phase == PH_RX_WAIT);

   p_tx_hold_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (en && phase == PH_HOLD && !first && rd_req && txe_pend && !stop_det && !start_det)
      |=> phase == PH_HOLD);

   p_forced_nack_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (en && phase == PH_RX_WAIT && !rxd_pend && !ev.rxd && force_nack
       && !stop_det && !start_det) |=> !sda_low);

   p_quiet_off_r12 : assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (phase == PH_IDLE && !sda_low));

endmodule

// File: rtl/i2ct_regs.sv
module i2ct_regs
   import i2ct_pkg::*;
#(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   input  logic             we,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata,
   input  evt_t             ev,
   input  logic [DW-1:0]    rx_byte,
   output logic [CT_W-1:0]  ctrl,
   output logic [AW-1:0]    own_addr,
   output logic [DW-1:0]    tx_byte,
   output logic [ST_W-1:0]  status,
   output logic             irq
);

   logic [ST_W-1:0] ien, keep, setv;
   logic            wr_stat;

   assign wr_stat = we && (sel == SEL_W'(RA_STAT));

   always_comb begin
      setv         = '0;
      setv[ST_AM]  = ev.am;
      setv[ST_RXD] = ev.rxd;
      setv[ST_TXD] = ev.txd;
      setv[ST_TXE] = ev.txe;
      setv[ST_STP] = ev.stp;
      setv[ST_GC]  = ev.gc;
      setv[ST_TXM] = ev.tm_set;
      keep         = wr_stat ? wdata[ST_W-1:0] : '1;
      keep[ST_TXM] = keep[ST_TXM] & ~ev.tm_clr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl     <= '0;
         ien      <= '0;
         own_addr <= '0;
         tx_byte  <= '0;
         status   <= '0;
      end else begin
         status <= (status & keep) | setv;
         if (we) begin
            case (sel)
               SEL_W'(RA_CTRL): ctrl     <= wdata[CT_W-1:0];
               SEL_W'(RA_IEN):  ien      <= wdata[ST_W-1:0];
               SEL_W'(RA_OWN):  own_addr <= wdata[AW-1:0];
               SEL_W'(RA_DATA): tx_byte  <= wdata;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (sel)
         SEL_W'(RA_CTRL): rdata = DW'(ctrl);
         SEL_W'(RA_STAT): rdata = DW'(status);
         SEL_W'(RA_IEN):  rdata = DW'(ien);
         SEL_W'(RA_OWN):  rdata = DW'(own_addr);
         SEL_W'(RA_DATA): rdata = rx_byte;
         default:         rdata = '0;
      endcase
   end

   assign irq = |(status & ien);

   p_w0c_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && ev == '0) |=> status == ($past(status) & $past(wdata[ST_W-1:0])));

   p_rx_flag_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      ev.rxd |=> status[ST_RXD]);

endmodule

// File: rtl/i2c_target_core.sv
module i2c_target_core
   import i2ct_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int SEL_W       = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] reg_sel,
   input  logic             reg_we,
   input  logic [7:0]       reg_wdata,
   output logic [7:0]       reg_rdata,
   output logic             irq,
   input  logic             scl_in,
   input  logic             sda_in,
   output logic             scl_oe,
   output logic             sda_oe
);

   logic            sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic [CT_W-1:0] ctrl;
   logic [AW-1:0]   own_addr;
   logic [DW-1:0]   tx_byte, rx_byte;
   logic [ST_W-1:0] status;
   evt_t            ev;

   i2ct_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_in    (scl_in),
      .sda_in    (sda_in),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2ct_regs #(.SEL_W(SEL_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (reg_sel),
      .we       (reg_we),
      .wdata    (reg_wdata),
      .rdata    (reg_rdata),
      .ev       (ev),
      .rx_byte  (rx_byte),
      .ctrl     (ctrl),
      .own_addr (own_addr),
      .tx_byte  (tx_byte),
      .status   (status),
      .irq      (irq)
   );

   i2ct_engine u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .sda_s      (sda_s),
      .scl_rise   (scl_rise),
      .scl_fall   (scl_fall),
      .start_det  (start_det),
      .stop_det   (stop_det),
      .en         (ctrl[CT_EN]),
      .gc_en      (ctrl[CT_GCEN]),
      .force_nack (ctrl[CT_NACK]),
      .own_addr   (own_addr),
      .tx_byte    (tx_byte),
      .am_pend    (status[ST_AM]),
      .rxd_pend   (status[ST_RXD]),
      .txe_pend   (status[ST_TXE]),
      .sda_low    (sda_oe),
      .scl_low    (scl_oe),
      .rx_byte    (rx_byte),
      .ev         (ev)
   );

   p_bus_release_r12 : assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl[CT_EN] |=> (!scl_oe && !sda_oe));

   p_stop_flag_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      ev.stp |=> status[ST_STP]);

endmodule

// File: tb/i2c_target_core_bench.sv
`timescale 1ns/1ps
module i2c_target_core_bench;

   localparam int Q = 10;
   localparam logic [2:0] S_CTRL = 3'd0, S_STAT = 3'd1, S_IEN = 3'd2, S_OWN = 3'd3, S_DATA = 3'd4;
   localparam logic [6:0] OWN = 7'h2D;
   localparam int NV = 8;
   // fields: addr[19:13] data[12:5] en[4] gc[3] fn[2] exp_addr_ack[1] exp_data_ack[0]
   localparam logic [19:0] VEC [NV] = '{
      {7'h2D, 8'hA5, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
      {7'h2D, 8'h3C, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
      {7'h2C, 8'h11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
      {7'h00, 8'h81, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
      {7'h00, 8'h42, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
      {7'h6D, 8'h55, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
      {7'h2D, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      {7'h2D, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}
   };

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic       rst_n;
   logic [2:0] reg_sel;
   logic       reg_we;
   logic [7:0] reg_wdata, reg_rdata;
   logic       irq, scl_oe, sda_oe;
   logic       m_scl_low, m_sda_low;
   logic       scl_line, sda_line;
   int         checks = 0, fails = 0;
   bit         done = 1'b0;

   assign scl_line = ~(m_scl_low | scl_oe);
   assign sda_line = ~(m_sda_low | sda_oe);

   i2c_target_core u_i2c_target_core (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
      .scl_in(scl_line), .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_q();
      repeat (Q) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] s, input logic [7:0] d);
      @(negedge clk);
      reg_sel = s; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic rd(input logic [2:0] s, output logic [7:0] d);
      @(negedge clk);
      reg_sel = s;
      #1 d = reg_rdata;
   endtask

   task automatic bit_clock(output logic s);
      m_scl_low = 1'b0;
      while (!scl_line) @(negedge clk);
      wait_q();
      s = sda_line;
      wait_q();
      m_scl_low = 1'b1;
      wait_q();
   endtask

   task automatic put_bits(input logic [7:0] b);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         m_sda_low = ~b[i];
         wait_q();
         bit_clock(s);
      end
      m_sda_low = 1'b0;
   endtask

   task automatic get_bits(output logic [7:0] b);
      logic s;
      m_sda_low = 1'b0;
      b = '0;
      for (int i = 0; i < 8; i++) begin
         wait_q();
         bit_clock(s);
         b = {b[6:0], s};
      end
   endtask

   task automatic get_ack(output logic ack);
      logic s;
      m_sda_low = 1'b0;
      wait_q();
      bit_clock(s);
      ack = ~s;
   endtask

   task automatic put_ack(input logic a);
      logic s;
      m_sda_low = a;
      wait_q();
      bit_clock(s);
      m_sda_low = 1'b0;
   endtask

   task automatic bus_start();
      m_sda_low = 1'b0; m_scl_low = 1'b0;
      wait_q();
      m_sda_low = 1'b1;
      wait_q();
      m_scl_low = 1'b1;
      wait_q();
   endtask

   task automatic bus_stop();
      m_sda_low = 1'b1;
      wait_q();
      m_scl_low = 1'b0;
      while (!scl_line) @(negedge clk);
      wait_q();
      m_sda_low = 1'b0;
      wait_q();
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         finish_run();
      end
   end

   initial begin
      logic [7:0] d;
      logic       a;
      rst_n = 1'b0; reg_sel = '0; reg_we = 1'b0; reg_wdata = '0;
      m_scl_low = 1'b0; m_sda_low = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R1 reset state
      for (int r = 0; r < 5; r++) begin
         rd(3'(r), d);
         check("R1 register reset", d, 8'h00);
      end
      check("R1 irq reset", irq, 1'b0);
      check("R1 lines released", {scl_oe, sda_oe}, 2'b00);

      wr(S_OWN, {1'b0, OWN});
      wr(S_IEN, 8'h00);

      // table of write transfers: R2 R6 R7 R8 R10 R11 R12
      for (int v = 0; v < NV; v++) begin
         logic [7:0] gcb;
         gcb = (VEC[v][19:13] == 7'h00) ? 8'h40 : 8'h00;
         wr(S_CTRL, {5'b0, VEC[v][4], VEC[v][3], 1'b0});
         wr(S_STAT, 8'h00);
         bus_start();
         put_bits({VEC[v][19:13], 1'b0});
         get_ack(a);
         check("R2/R11/R12 address ack", a, VEC[v][1]);
         if (VEC[v][1]) begin
            rd(S_STAT, d);
            check("R2/R11 match flags", d, gcb | 8'h01);
            check("R7 hold after address", scl_oe, 1'b1);
            rd(S_DATA, d);
            wr(S_STAT, 8'hFE);
            wait_q();
            check("R7 release after service", scl_oe, 1'b0);
            put_bits(VEC[v][12:5]);
            wait_q();
            rd(S_DATA, d);
            check("R6 received byte", d, VEC[v][12:5]);
            rd(S_STAT, d);
            check("R6 receive flag", d, gcb | 8'h02);
            check("R7 hold before data ack", scl_oe, 1'b1);
            wr(S_CTRL, {5'b0, VEC[v][4], VEC[v][3], VEC[v][2]});
            wr(S_STAT, 8'hFD);
            get_ack(a);
            check("R8 data ack follows refuse bit", a, VEC[v][0]);
            bus_stop();
            rd(S_STAT, d);
            check("R10 stop flag", d, gcb | 8'h10);
            check("R10 lines released", {scl_oe, sda_oe}, 2'b00);
         end else begin
            bus_stop();
            rd(S_STAT, d);
            check("R2/R12 no flags on mismatch", d, 8'h00);
         end
      end

      // directed read transfer: R4 R5 R7 R9 R10 R3
      wr(S_CTRL, 8'h04);
      wr(S_STAT, 8'h00);
      wr(S_IEN, 8'h00);
      bus_start();
      put_bits({OWN, 1'b1});
      get_ack(a);
      check("R2 read address ack", a, 1'b1);
      rd(S_STAT, d);
      check("R5 transmit direction flag", d, 8'h21);
      check("R4 irq masked", irq, 1'b0);
      wr(S_IEN, 8'h01);
      check("R4 irq enabled", irq, 1'b1);
      wr(S_DATA, 8'hC3);
      wr(S_STAT, 8'hFE);
      check("R4 irq cleared", irq, 1'b0);
      wait_q();
      check("R7 release for first tx byte", scl_oe, 1'b0);
      get_bits(d);
      check("R5 first byte sent", d, 8'hC3);
      rd(S_STAT, d);
      check("R5 data empty flag", d, 8'h28);
      put_ack(1'b1);
      rd(S_STAT, d);
      check("R9 transmitted flag on ack", d, 8'h2C);
      check("R7 hold while data empty", scl_oe, 1'b1);
      wr(S_DATA, 8'h96);
      wr(S_STAT, 8'hF3);
      get_bits(d);
      check("R5 second byte sent", d, 8'h96);
      put_ack(1'b0);
      check("R9 SDA released after nack", sda_oe, 1'b0);
      rd(S_STAT, d);
      check("R9 no transmitted flag on nack", d, 8'h28);
      bus_stop();
      rd(S_STAT, d);
      check("R10 stop after read", d, 8'h38);
      wr(S_STAT, 8'hEF);
      rd(S_STAT, d);
      check("R3 clear only zero-written bit", d, 8'h28);
      wr(S_STAT, 8'hD7);
      rd(S_STAT, d);
      check("R3 clear two bits", d, 8'h00);

      done = 1'b1;
      finish_run();
   end

endmodule